// File: doc/BRIEF.md
# Programmable Time-Base Interrupt Generator

This block divides the main oscillator clock by one of four ratios chosen by software and raises a timeout flag once per period. The result is a steady tick for a real-time clock or a scheduler. Software reaches the block through one 8-bit control/status register. In that register it picks the ratio, enables the interrupt, and observes the flag. Reading the register acknowledges the flag.

A change of ratio does not cut the running period short. The new ratio is held and loaded only when the current period ends, so a tick never lands at an odd time. The block also follows a four-level power mode code. In the two light sleep modes the counter keeps running and a pending interrupt asks to wake the device. In deep halt the counter and register freeze, no request leaves the block, and counting continues from the frozen value once the device wakes by some other means.

A parameter divides all four ratios by a common factor for fast simulation. Their proportions stay the same.

Top module: `tbase_tick`

## Requirements
- R1: After reset the register reads 8'h00, and `irq_req` and `wake_req` are 0.
- R2: The select code (register bits 3:2) sets the period in oscillator cycles, each divided by `SCALE_DIV`: code 0 gives 16000, code 1 gives 32000, code 2 gives 80000 and code 3 gives 200000. The first period after reset uses code 0, and the flag rises the clock edge after the counter's last count.
- R3: A written select code takes effect only from the period that follows the one running when it was written.
- R4: The register reads as {4'b0000, select[1:0], enable, flag}. Writes update the select and enable bits. Written values of bits 7:4 and bit 0 are ignored.
- R5: Only the end of a period sets the flag. A write cannot set or clear it. A register read (`bus_rd` high at a clock edge) clears it.
- R6: When a period ends in the same cycle as a register read, the flag ends up set.
- R7: `irq_req` is high exactly when the flag is 1, the enable bit is 1, `irq_mask` is 0 and the mode is not halt.
- R8: Mode codes are run=0, wait=1, active-halt=2, halt=3. The counter runs at full rate in wait and active-halt. `wake_req` is high exactly when `irq_req` is high and the mode is wait or active-halt.
- R9: In halt the counter and register hold their values, reads and writes have no effect, and `irq_req` and `wake_req` are 0. After halt, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears the flag) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks the request |
| pwr_mode | input | 2 | Power mode: 0 run, 1 wait, 2 active-halt, 3 halt |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request from wait or active-halt |

## Verification
Two events can fall in the same cycle: the counter's terminal count, which sets the flag, and a software read, which clears it. The bench holds the read strobe high across the exact edge on which the period ends. It then expects the flag still set, and expects a second read to clear it. A read issued during halt is also checked: afterwards the flag must be unchanged.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // power mode code carried on pwr_mode
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_WAIT  = 2'd1,
    PM_AHALT = 2'd2,
    PM_HALT  = 2'd3
  } pwr_mode_e;

  // software-visible register contents
  typedef struct packed {
    logic [1:0] sel;
    logic       ie;
    logic       flag;
  } csr_t;

  localparam int unsigned CSR_W = 8;

  // unscaled period for a select code, in oscillator cycles
  function automatic int unsigned base_period(logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd16000;
      2'd1:    return 32'd32000;
      2'd2:    return 32'd80000;
      default: return 32'd200000;
    endcase
  endfunction

  // period after simulation scaling
  function automatic int unsigned period_of(logic [1:0] sel, int unsigned scale);
    return base_period(sel) / scale;
  endfunction

  // register image seen on the bus
  function automatic logic [CSR_W-1:0] pack_csr(csr_t c);
    return {4'b0000, c.sel, c.ie, c.flag};
  endfunction

endpackage

// File: rtl/tbase_divider.sv
module tbase_divider
  import tbase_pkg::*;
#(
  parameter int unsigned SCALE_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel_req,
  output logic       tick
);

  localparam int unsigned MAX_PERIOD = period_of(2'd3, SCALE_DIV);
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       sel_act;   // ratio of the running period
  logic [CNT_W-1:0] last_cnt;

  // the last count value of the running period
  assign last_cnt = CNT_W'(period_of(sel_act, SCALE_DIV) - 1);
  assign tick     = run && (cnt == last_cnt);

  // wrap to zero at the period end and load the held ratio there
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_act <= 2'd0;
    end else if (tick) begin
      cnt     <= '0;
      sel_act <= sel_req;
    end else if (run) begin
      cnt     <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic       tick,
  output csr_t       csr
);

  // bits 7:4 and bit 0 of the write data have no destination
  logic unused_wbits;
  assign unused_wbits = ^{wdata[7:4], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr <= '0;
    end else if (run) begin
      if (wr) begin
        csr.sel <= wdata[3:2];
        csr.ie  <= wdata[1];
      end
      // a period end outranks an acknowledging read
      if (tick)
        csr.flag <= 1'b1;
      else if (rd)
        csr.flag <= 1'b0;
    end
  end

endmodule

// File: rtl/tbase_irq.sv
module tbase_irq
  import tbase_pkg::*;
(
  input  csr_t       csr,
  input  logic       irq_mask,
  input  pwr_mode_e  mode,
  output logic       irq_req,
  output logic       wake_req
);

  logic irq_pending;

  assign irq_pending = csr.flag && csr.ie && !irq_mask;
  assign irq_req     = irq_pending && (mode != PM_HALT);
  assign wake_req    = irq_req && ((mode == PM_WAIT) || (mode == PM_AHALT));

endmodule

// File: rtl/tbase_tick.sv
module tbase_tick
  import tbase_pkg::*;
#(
  parameter int unsigned SCALE_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_mask,
  input  logic [1:0] pwr_mode,
  output logic       irq_req,
  output logic       wake_req
);

  pwr_mode_e mode;
  logic      run;
  logic      period_end;   // counter wraps this cycle
  csr_t      csr;

  assign mode = pwr_mode_e'(pwr_mode);
  assign run  = (mode != PM_HALT);

  tbase_divider #(.SCALE_DIV(SCALE_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sel_req (csr.sel),
    .tick    (period_end)
  );

  tbase_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .wdata (bus_wdata),
    .tick  (period_end),
    .csr   (csr)
  );

  tbase_irq u_irq (
    .csr      (csr),
    .irq_mask (irq_mask),
    .mode     (mode),
    .irq_req  (irq_req),
    .wake_req (wake_req)
  );

  assign bus_rdata = pack_csr(csr);

endmodule

// File: rtl/tbase_tick_chk.sv
module tbase_tick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_mask,
  input logic [1:0] pwr_mode,
  input logic       irq_req,
  input logic       wake_req,
  input logic       period_end
);

  logic halt;
  assign halt = (pwr_mode == 2'd3);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:4] == 4'h0); // R4

  AST_WRITE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !halt) |=> (bus_rdata[3:1] == $past(bus_wdata[3:1]))); // R4

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[0]) |-> $past(period_end)); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !period_end && !halt) |=> !bus_rdata[0]); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> bus_rdata[0]); // R6

  AST_IRQ_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (bus_rdata[0] && bus_rdata[1] && !irq_mask && !halt)); // R7

  AST_WAKE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (irq_req && (pwr_mode == 2'd1 || pwr_mode == 2'd2))); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!irq_req && !wake_req && !period_end)); // R9

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(bus_rdata)); // R9

endmodule

bind tbase_tick tbase_tick_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_mask   (irq_mask),
  .pwr_mode   (pwr_mode),
  .irq_req    (irq_req),
  .wake_req   (wake_req),
  .period_end (period_end)
);

// File: tb/tbase_tick_test.sv
module tbase_tick_test;

  localparam int unsigned SCALE = 1000;

  // one table row: select, enable, mask, expected irq, expected period
  typedef struct packed {
    logic [1:0] sel;
    logic       ie;
    logic       mask;
    logic       exp_irq;
    logic [7:0] per;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 1'b0, 1'b1, 8'd16},
    '{2'd1, 1'b1, 1'b1, 1'b0, 8'd32},
    '{2'd2, 1'b0, 1'b0, 1'b0, 8'd80},
    '{2'd3, 1'b1, 1'b0, 1'b1, 8'd200}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_mask = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic       irq_req;
  logic       wake_req;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;   // edges since reset release

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  tbase_tick #(.SCALE_DIV(SCALE)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_mask  (irq_mask),
    .pwr_mode  (pwr_mode),
    .irq_req   (irq_req),
    .wake_req  (wake_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    irq_mask = 1'b0; pwr_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] v);
    bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read();
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_flag(output int at);
    int n = 0;
    while (!bus_rdata[0] && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 1000) check("R2 flag timeout", 0, 1);
    at = ecnt;
  endtask

  task automatic wait_edge(input int e);
    while (ecnt < e) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t1;
    int t2;

    // R1: reset state
    do_reset();
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", irq_req, 0);
    check("R1 wake", wake_req, 0);

    // table: ratio per select, deferred load, irq gating
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      irq_mask = VECS[i].mask;
      bus_write({4'b0000, VECS[i].sel, VECS[i].ie, 1'b0});
      wait_flag(t1);
      check("R3 first period keeps old ratio", t1, 16);
      check("R7 irq gating", irq_req, VECS[i].exp_irq);
      bus_read();
      wait_flag(t2);
      check("R2 period for select", t2 - t1, VECS[i].per);
    end

    // R4: field layout and ignored bits
    do_reset();
    bus_write(8'hFF);
    check("R4 write all ones", bus_rdata, 8'h0E);
    wait_flag(t1);
    check("R4 flag bit position", bus_rdata, 8'h0F);
    bus_write(8'h00);
    check("R5 write does not clear flag", bus_rdata, 8'h01);
    bus_read();
    bus_write(8'h01);
    check("R5 write does not set flag", bus_rdata, 8'h00);

    // R6: read on the terminal edge
    do_reset();
    wait_edge(15);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R6 edge of collision", ecnt, 16);
    check("R6 set wins over read", bus_rdata[0], 1);
    bus_read();
    check("R5 read clears flag", bus_rdata[0], 0);

    // R8: wake in active-halt and wait
    do_reset();
    bus_write(8'h02);
    pwr_mode = 2'd2;
    wait_flag(t1);
    check("R8 counts in active-halt", t1, 16);
    check("R8 wake in active-halt", wake_req, 1);
    pwr_mode = 2'd1;
    #1;
    check("R8 wake in wait", wake_req, 1);
    irq_mask = 1'b1;
    #1;
    check("R8 masked no wake", wake_req, 0);
    irq_mask = 1'b0;
    pwr_mode = 2'd0;
    #1;
    check("R8 no wake in run", wake_req, 0);
    check("R7 irq in run", irq_req, 1);

    // R9: halt freezes the counter
    do_reset();
    wait_edge(10);
    pwr_mode = 2'd3;
    repeat (50) @(negedge clk);
    check("R9 no flag during halt", bus_rdata[0], 0);
    pwr_mode = 2'd0;
    wait_flag(t1);
    check("R9 resumes from held count", t1, 66);

    // R9: held flag, quiet outputs, read ignored
    do_reset();
    bus_write(8'h02);
    wait_flag(t1);
    pwr_mode = 2'd3;
    #1;
    check("R9 irq quiet in halt", irq_req, 0);
    check("R9 wake quiet in halt", wake_req, 0);
    bus_read();
    bus_write(8'h0C);
    pwr_mode = 2'd0;
    #1;
    check("R9 read and write ignored in halt", bus_rdata, 8'h03);
    check("R7 irq returns after halt", irq_req, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule